// File: doc/BRIEF.md
# UART Descriptor-Driven Buffer Mover

This block sits between a byte-level asynchronous serial engine (8 data bits, no parity, one stop bit) and system memory. It moves characters using a single receive descriptor and a single transmit descriptor. Each descriptor is a 16-bit status word, a byte count and a buffer address, all held in a small register file that software reaches through a simple write/read configuration port.

Incoming characters go to consecutive addresses of the receive buffer. When a programmed maximum count is reached, the buffer is closed: the descriptor's ready flag drops and the actual count is written back. A character that arrives while no receive descriptor is ready is not stored; it raises a busy (out-of-buffers) event instead. The transmit side fetches the programmed number of bytes from memory, hands them one at a time to the serial engine, and then closes its descriptor. Three event bits, gated by a mask register, form an interrupt request.

Software is expected to program the descriptors, the maximum length, the mask and the event clear first. It turns on the receive and transmit enables last.

Top module: `uart_bd_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq`, `tx_valid` and `mem_en` are low. The register word addresses are: 0 receive status, 1 receive length, 2 receive pointer, 3 transmit status, 4 transmit length, 5 transmit pointer, 6 maximum receive length, 7 events, 8 mask, 9 mode (bit 0 receive enable, bit 1 transmit enable). Unmapped addresses read zero.
- R2: With receive enabled and receive status bit 15 (ready) set, each `rx_valid` pulse writes `rx_data` to memory in the same cycle, at the receive pointer plus the number of characters already stored in that buffer.
- R3: When the stored count reaches the maximum receive length, the receive descriptor closes. Status bit 15 clears, the receive length register takes the stored count, and, if status bit 12 (interrupt on close) is set, event bit 0 is set.
- R4: A character that arrives with receive enabled but status bit 15 clear writes no memory and sets event bit 2 (busy). This includes a character that arrives in the cycle right after a close.
- R5: With receive disabled (mode bit 0 clear), a character is ignored: no memory write and no event.
- R6: With transmit enabled and transmit status bit 15 set, the block reads the transmit-length count of bytes in order, starting at the transmit pointer. It presents each byte on `tx_data` with `tx_valid` held, and `tx_data` stable, until `tx_ready` is high.
- R7: When the last byte is accepted, transmit status bit 15 clears, the transmit length stays unchanged, and event bit 1 is set if status bit 12 is set. A zero length closes at once, and no byte is sent.
- R8: Writing the event register clears each event bit written as one. Writing 0xFFFF clears all of them. A hardware set in the same cycle wins.
- R9: `irq` is high exactly when some event bit and the matching mask bit are both set (mask 0x0003 enables receive-closed and transmit-closed).
- R10: A descriptor closed with status bit 12 clear still drops bit 15 and writes back its count, but it sets no event.
- R11: A receive write and a transmit fetch in the same cycle are resolved in favour of the write. The fetch waits, and no byte of either stream is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| rx_valid | input | 1 | One-cycle pulse: a received character is available |
| rx_data | input | 8 | Received character |
| tx_valid | output | 1 | A character is offered to the serial engine |
| tx_data | output | 8 | Character to send |
| tx_ready | input | 1 | Serial engine accepts the offered character |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `rx_valid` is a single-cycle pulse. They also assume that memory always accepts a request and returns read data exactly one cycle later, and that software does not rewrite an armed descriptor while it is in use. The bench keeps to these rules. Its memory model answers every read with a value computed from the address one cycle later. Receive pulses are driven for one cycle only, both spaced and back to back. A descriptor is re-armed only after its close has been read back. `tx_ready` follows a fixed stall pattern, so the hold rule on `tx_data` is exercised while receive writes collide with transmit fetches.

// File: rtl/uart_bd_pkg.sv
package uart_bd_pkg;
   localparam int CFG_AW = 4;
   localparam int CFG_DW = 32;
   localparam int EVT_W  = 3;

   localparam logic [CFG_AW-1:0] REG_RX_STAT = 4'd0;
   localparam logic [CFG_AW-1:0] REG_RX_LEN  = 4'd1;
   localparam logic [CFG_AW-1:0] REG_RX_PTR  = 4'd2;
   localparam logic [CFG_AW-1:0] REG_TX_STAT = 4'd3;
   localparam logic [CFG_AW-1:0] REG_TX_LEN  = 4'd4;
   localparam logic [CFG_AW-1:0] REG_TX_PTR  = 4'd5;
   localparam logic [CFG_AW-1:0] REG_MAX_LEN = 4'd6;
   localparam logic [CFG_AW-1:0] REG_EVENT   = 4'd7;
   localparam logic [CFG_AW-1:0] REG_MASK    = 4'd8;
   localparam logic [CFG_AW-1:0] REG_MODE    = 4'd9;

   localparam int BIT_READY = 15;
   localparam int BIT_WRAP  = 13;
   localparam int BIT_INT   = 12;

   localparam int EV_RXDONE = 0;
   localparam int EV_TXDONE = 1;
   localparam int EV_BUSY   = 2;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_FETCH = 2'd1,
      TX_WAIT  = 2'd2,
      TX_SEND  = 2'd3
   } tx_state_e;
endpackage

// File: rtl/uart_bd_regs.sv
module uart_bd_regs
   import uart_bd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [CFG_DW-1:0]    cfg_wdata,
   output logic [CFG_DW-1:0]    cfg_rdata,
   input  logic                 rx_close_i,
   input  logic [LEN_W-1:0]     rx_close_len_i,
   input  logic                 tx_close_i,
   input  logic                 busy_i,
   output logic [15:0]          rx_stat_o,
   output logic [ADDR_W-1:0]    rx_ptr_o,
   output logic [LEN_W-1:0]     max_len_o,
   output logic [15:0]          tx_stat_o,
   output logic [LEN_W-1:0]     tx_len_o,
   output logic [ADDR_W-1:0]    tx_ptr_o,
   output logic [EVT_W-1:0]     evt_o,
   output logic [EVT_W-1:0]     mask_o,
   output logic                 rx_en_o,
   output logic                 tx_en_o
);
   logic [15:0]       rx_stat_q, tx_stat_q;
   logic [LEN_W-1:0]  rx_len_q, tx_len_q, max_len_q;
   logic [ADDR_W-1:0] rx_ptr_q, tx_ptr_q;
   logic [EVT_W-1:0]  evt_q, mask_q, evt_set, evt_clr;
   logic [1:0]        mode_q;
   logic              unused_wdata;

   assign unused_wdata = ^cfg_wdata;

   function automatic logic hit(input logic [CFG_AW-1:0] a);
      return cfg_we && (cfg_addr == a);
   endfunction

   always_comb begin
      evt_set            = '0;
      evt_set[EV_RXDONE] = rx_close_i && rx_stat_q[BIT_INT];
      evt_set[EV_TXDONE] = tx_close_i && tx_stat_q[BIT_INT];
      evt_set[EV_BUSY]   = busy_i;
      evt_clr            = hit(REG_EVENT) ? cfg_wdata[EVT_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_stat_q <= '0;
         tx_stat_q <= '0;
         rx_len_q  <= '0;
         tx_len_q  <= '0;
         max_len_q <= '0;
         rx_ptr_q  <= '0;
         tx_ptr_q  <= '0;
         evt_q     <= '0;
         mask_q    <= '0;
         mode_q    <= '0;
      end else begin
         if (hit(REG_RX_STAT)) rx_stat_q <= cfg_wdata[15:0];
         if (rx_close_i)       rx_stat_q[BIT_READY] <= 1'b0;
         if (hit(REG_RX_LEN))  rx_len_q <= cfg_wdata[LEN_W-1:0];
         if (rx_close_i)       rx_len_q <= rx_close_len_i;
         if (hit(REG_RX_PTR))  rx_ptr_q <= cfg_wdata[ADDR_W-1:0];
         if (hit(REG_TX_STAT)) tx_stat_q <= cfg_wdata[15:0];
         if (tx_close_i)       tx_stat_q[BIT_READY] <= 1'b0;
         if (hit(REG_TX_LEN))  tx_len_q <= cfg_wdata[LEN_W-1:0];
         if (hit(REG_TX_PTR))  tx_ptr_q <= cfg_wdata[ADDR_W-1:0];
         if (hit(REG_MAX_LEN)) max_len_q <= cfg_wdata[LEN_W-1:0];
         if (hit(REG_MASK))    mask_q <= cfg_wdata[EVT_W-1:0];
         if (hit(REG_MODE))    mode_q <= cfg_wdata[1:0];
         evt_q <= (evt_q & ~evt_clr) | evt_set;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_addr)
         REG_RX_STAT: cfg_rdata[15:0]       = rx_stat_q;
         REG_RX_LEN:  cfg_rdata[LEN_W-1:0]  = rx_len_q;
         REG_RX_PTR:  cfg_rdata[ADDR_W-1:0] = rx_ptr_q;
         REG_TX_STAT: cfg_rdata[15:0]       = tx_stat_q;
         REG_TX_LEN:  cfg_rdata[LEN_W-1:0]  = tx_len_q;
         REG_TX_PTR:  cfg_rdata[ADDR_W-1:0] = tx_ptr_q;
         REG_MAX_LEN: cfg_rdata[LEN_W-1:0]  = max_len_q;
         REG_EVENT:   cfg_rdata[EVT_W-1:0]  = evt_q;
         REG_MASK:    cfg_rdata[EVT_W-1:0]  = mask_q;
         REG_MODE:    cfg_rdata[1:0]        = mode_q;
         default:     cfg_rdata             = '0;
      endcase
   end

   assign rx_stat_o = rx_stat_q;
   assign rx_ptr_o  = rx_ptr_q;
   assign max_len_o = max_len_q;
   assign tx_stat_o = tx_stat_q;
   assign tx_len_o  = tx_len_q;
   assign tx_ptr_o  = tx_ptr_q;
   assign evt_o     = evt_q;
   assign mask_o    = mask_q;
   assign rx_en_o   = mode_q[0];
   assign tx_en_o   = mode_q[1];
endmodule

// File: rtl/uart_bd_rx.sv
module uart_bd_rx #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en_i,
   input  logic              ready_i,
   input  logic [ADDR_W-1:0] ptr_i,
   input  logic [LEN_W-1:0]  max_len_i,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_data_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              close_o,
   output logic [LEN_W-1:0]  close_len_o,
   output logic              busy_o
);
   logic [LEN_W-1:0] cnt_q, cnt_nxt;
   logic             take;

   assign take        = rx_valid_i && rx_en_i && ready_i;
   assign busy_o      = rx_valid_i && rx_en_i && !ready_i;
   assign cnt_nxt     = cnt_q + LEN_W'(1);
   assign close_o     = take && (cnt_nxt == max_len_i);
   assign close_len_o = cnt_nxt;
   assign wr_en_o     = take;
   assign wr_addr_o   = ptr_i + ADDR_W'(cnt_q);
   assign wr_data_o   = rx_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!rx_en_i || close_o) cnt_q <= '0;
      else if (take)              cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/uart_bd_tx.sv
module uart_bd_tx
   import uart_bd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en_i,
   input  logic              ready_i,
   input  logic [ADDR_W-1:0] ptr_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_gnt_i,
   input  logic [7:0]        rd_data_i,
   output logic              tx_valid_o,
   output logic [7:0]        tx_data_o,
   input  logic              tx_ready_i,
   output logic              close_o
);
   tx_state_e        state_q;
   logic [LEN_W-1:0] cnt_q, cnt_nxt;
   logic [7:0]       byte_q;
   logic             last, start_ok;

   assign cnt_nxt    = cnt_q + LEN_W'(1);
   assign last       = (cnt_nxt == len_i);
   assign start_ok   = tx_en_i && ready_i;
   assign rd_req_o   = (state_q == TX_FETCH);
   assign rd_addr_o  = ptr_i + ADDR_W'(cnt_q);
   assign tx_valid_o = (state_q == TX_SEND);
   assign tx_data_o  = byte_q;

   always_comb begin
      close_o = 1'b0;
      if (state_q == TX_IDLE && start_ok && len_i == '0) close_o = 1'b1;
      if (state_q == TX_SEND && tx_ready_i && last)       close_o = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         cnt_q   <= '0;
         byte_q  <= '0;
      end else begin
         unique case (state_q)
            TX_IDLE: begin
               cnt_q <= '0;
               if (start_ok && len_i != '0) state_q <= TX_FETCH;
            end
            TX_FETCH: if (rd_gnt_i) state_q <= TX_WAIT;
            TX_WAIT: begin
               byte_q  <= rd_data_i;
               state_q <= TX_SEND;
            end
            TX_SEND: begin
               if (tx_ready_i) begin
                  if (last) begin
                     state_q <= TX_IDLE;
                  end else begin
                     cnt_q   <= cnt_nxt;
                     state_q <= TX_FETCH;
                  end
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_bd_ctrl.sv
module uart_bd_ctrl
   import uart_bd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              irq
);
   if (ADDR_W < LEN_W || ADDR_W > CFG_DW) begin : g_bad_addr_w
      $error("ADDR_W must lie between LEN_W and the config data width");
   end
   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len_w
      $error("LEN_W must lie between 2 and 16");
   end

   logic [15:0]       rx_stat_w, tx_stat_w;
   logic [ADDR_W-1:0] rx_ptr_w, tx_ptr_w, rx_waddr, tx_raddr;
   logic [LEN_W-1:0]  max_len_w, tx_len_w, rx_close_len;
   logic [EVT_W-1:0]  evt_w, mask_w;
   logic              rx_en_w, tx_en_w, rx_close_w, tx_close_w, busy_w;
   logic              rx_wr, tx_rd;
   logic [7:0]        rx_wdata;

   uart_bd_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .rx_close_i(rx_close_w), .rx_close_len_i(rx_close_len),
      .tx_close_i(tx_close_w), .busy_i(busy_w),
      .rx_stat_o(rx_stat_w), .rx_ptr_o(rx_ptr_w), .max_len_o(max_len_w),
      .tx_stat_o(tx_stat_w), .tx_len_o(tx_len_w), .tx_ptr_o(tx_ptr_w),
      .evt_o(evt_w), .mask_o(mask_w), .rx_en_o(rx_en_w), .tx_en_o(tx_en_w)
   );

   uart_bd_rx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .rx_en_i(rx_en_w), .ready_i(rx_stat_w[BIT_READY]),
      .ptr_i(rx_ptr_w), .max_len_i(max_len_w),
      .rx_valid_i(rx_valid), .rx_data_i(rx_data),
      .wr_en_o(rx_wr), .wr_addr_o(rx_waddr), .wr_data_o(rx_wdata),
      .close_o(rx_close_w), .close_len_o(rx_close_len), .busy_o(busy_w)
   );

   uart_bd_tx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .tx_en_i(tx_en_w), .ready_i(tx_stat_w[BIT_READY]),
      .ptr_i(tx_ptr_w), .len_i(tx_len_w),
      .rd_req_o(tx_rd), .rd_addr_o(tx_raddr), .rd_gnt_i(!rx_wr), .rd_data_i(mem_rdata),
      .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
      .close_o(tx_close_w)
   );

   // receive writes own the memory port; a pending fetch waits a cycle
   assign mem_en    = rx_wr || tx_rd;
   assign mem_we    = rx_wr;
   assign mem_addr  = rx_wr ? rx_waddr : tx_raddr;
   assign mem_wdata = rx_wdata;

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(evt_w & mask_w);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(evt_w & mask_w);
   end
endmodule

// File: rtl/uart_bd_chk.sv
module uart_bd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic       rx_en,
   input logic       rx_rdy,
   input logic       rx_close,
   input logic       busy_evt,
   input logic       mem_en,
   input logic       mem_we,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       tx_rdy
);
   assert_rx_write_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> (rx_rdy && rx_valid));

   assert_close_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_close |=> !rx_rdy);

   assert_busy_sets_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_en && !rx_rdy) |=> busy_evt);

   assert_no_write_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> !(mem_en && mem_we));

   assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   assert_tx_only_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_rdy);
endmodule

bind uart_bd_ctrl uart_bd_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .rx_valid(rx_valid), .rx_en(rx_en_w), .rx_rdy(rx_stat_w[15]),
   .rx_close(rx_close_w), .busy_evt(evt_w[2]),
   .mem_en(mem_en), .mem_we(mem_we),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
   .tx_rdy(tx_stat_w[15])
);

// File: tb/sim_uart_bd_ctrl.sv
module sim_uart_bd_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;
   logic        mem_en, mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        irq;

   int checks = 0;
   int bad = 0;
   logic [31:0] exp_wa[$];
   logic [7:0]  exp_wd[$];
   logic [7:0]  exp_tx[$];

   always #2.5 clk = ~clk;

   uart_bd_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_valid(rx_valid),
      .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
   );

   // memory model: reads return a pattern derived from the address, one cycle later
   always @(posedge clk)
      if (mem_en && !mem_we) mem_rdata <= mem_addr[7:0] ^ 8'h5A;

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, expv);
      end
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic peek(input logic [3:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string req);
      logic [31:0] v;
      peek(a, v);
      check(v == e, req, v, e);
   endtask

   task automatic send_rx(input logic [7:0] d, input logic stored, input logic [31:0] addr, input int gap);
      if (stored) begin
         exp_wa.push_back(addr);
         exp_wd.push_back(d);
      end
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = d;
      @(posedge clk); #1;
      rx_valid = 1'b0;
      repeat (gap) @(posedge clk);
   endtask

   task automatic wait_tx_done();
      logic [31:0] v;
      for (int i = 0; i < 400; i++) begin
         peek(4'd3, v);
         if (!v[15]) break;
      end
   endtask

   // stall pattern for the serial engine
   initial begin
      int k = 0;
      forever begin
         @(posedge clk); #1;
         k++;
         tx_ready = (k % 3) != 0;
      end
   end

   // scoreboard monitor: checks memory writes and accepted transmit bytes
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_en && mem_we) begin
            if (exp_wa.size() == 0) begin
               check(1'b0, "R4/R5 unexpected memory write", mem_addr, 32'h0);
            end else begin
               logic [31:0] ea;
               logic [7:0]  ed;
               ea = exp_wa.pop_front();
               ed = exp_wd.pop_front();
               check(mem_addr == ea, "R2 write address", mem_addr, ea);
               check(mem_wdata == ed, "R2 write data", {24'h0, mem_wdata}, {24'h0, ed});
            end
         end
         if (rst_n && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) begin
               check(1'b0, "R6 unexpected tx byte", {24'h0, tx_data}, 32'h0);
            end else begin
               logic [7:0] et;
               et = exp_tx.pop_front();
               check(tx_data == et, "R6 tx byte", {24'h0, tx_data}, {24'h0, et});
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'h0, 32'h0);
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 11; a++) expect_reg(4'(a), 32'h0, "R1 reset register");
      check(!irq && !tx_valid && !mem_en, "R1 reset outputs", {29'h0, irq, tx_valid, mem_en}, 32'h0);

      // R2/R3 receive four characters into an armed buffer
      wr(4'd6, 32'd4);
      wr(4'd2, 32'h1000);
      wr(4'd0, 32'hB000);
      wr(4'd8, 32'h3);
      wr(4'd7, 32'hFFFF);
      wr(4'd9, 32'h1);
      send_rx(8'h11, 1'b1, 32'h1000, 2);
      send_rx(8'h22, 1'b1, 32'h1001, 0);
      send_rx(8'h33, 1'b1, 32'h1002, 3);
      send_rx(8'h44, 1'b1, 32'h1003, 2);
      expect_reg(4'd0, 32'h3000, "R3 rx ready cleared");
      expect_reg(4'd1, 32'd4, "R3 rx length written back");
      expect_reg(4'd7, 32'h1, "R3 rx done event");
      check(irq == 1'b1, "R9 irq from rx done", {31'h0, irq}, 32'h1);

      // R4 busy: no ready descriptor
      send_rx(8'h55, 1'b0, 32'h0, 2);
      expect_reg(4'd7, 32'h5, "R4 busy event");
      // R8/R9 clear and mask
      wr(4'd7, 32'h1);
      expect_reg(4'd7, 32'h4, "R8 partial clear");
      check(irq == 1'b0, "R9 busy masked", {31'h0, irq}, 32'h0);
      wr(4'd8, 32'h7);
      check(irq == 1'b1, "R9 busy unmasked", {31'h0, irq}, 32'h1);
      wr(4'd7, 32'hFFFF);
      expect_reg(4'd7, 32'h0, "R8 clear all");
      check(irq == 1'b0, "R9 irq low after clear", {31'h0, irq}, 32'h0);

      // R5 receive disabled
      wr(4'd9, 32'h0);
      wr(4'd0, 32'hB000);
      send_rx(8'h66, 1'b0, 32'h0, 2);
      expect_reg(4'd7, 32'h0, "R5 no event when disabled");
      expect_reg(4'd0, 32'hB000, "R5 descriptor untouched");

      // R10 close without interrupt flag, back-to-back characters
      wr(4'd6, 32'd2);
      wr(4'd0, 32'h8000);
      wr(4'd9, 32'h1);
      send_rx(8'h77, 1'b1, 32'h1000, 0);
      send_rx(8'h88, 1'b1, 32'h1001, 2);
      expect_reg(4'd0, 32'h0000, "R10 ready cleared");
      expect_reg(4'd1, 32'd2, "R10 length written back");
      expect_reg(4'd7, 32'h0, "R10 no event");

      // R6/R7 transmit five bytes
      wr(4'd9, 32'h0);
      wr(4'd8, 32'h3);
      for (int i = 0; i < 5; i++) exp_tx.push_back(8'(32'h40 + i) ^ 8'h5A);
      wr(4'd5, 32'h2040);
      wr(4'd4, 32'd5);
      wr(4'd3, 32'hB000);
      wr(4'd9, 32'h2);
      wait_tx_done();
      check(exp_tx.size() == 0, "R6 all bytes sent", exp_tx.size(), 32'h0);
      expect_reg(4'd3, 32'h3000, "R7 tx ready cleared");
      expect_reg(4'd4, 32'd5, "R7 tx length unchanged");
      expect_reg(4'd7, 32'h2, "R7 tx done event");
      check(irq == 1'b1, "R9 irq from tx done", {31'h0, irq}, 32'h1);

      // R7 zero-length descriptor closes at once
      wr(4'd7, 32'hFFFF);
      wr(4'd4, 32'd0);
      wr(4'd3, 32'h9000);
      repeat (2) @(posedge clk);
      expect_reg(4'd3, 32'h1000, "R7 zero length closed");
      expect_reg(4'd7, 32'h2, "R7 zero length event");

      // R11 receive and transmit together on the shared memory port
      wr(4'd9, 32'h0);
      wr(4'd7, 32'hFFFF);
      for (int i = 0; i < 3; i++) exp_tx.push_back(8'(32'h50 + i) ^ 8'h5A);
      wr(4'd6, 32'd3);
      wr(4'd2, 32'h1080);
      wr(4'd0, 32'hB000);
      wr(4'd5, 32'h2050);
      wr(4'd4, 32'd3);
      wr(4'd3, 32'hB000);
      wr(4'd9, 32'h3);
      send_rx(8'hA1, 1'b1, 32'h1080, 0);
      send_rx(8'hA2, 1'b1, 32'h1081, 1);
      send_rx(8'hA3, 1'b1, 32'h1082, 0);
      wait_tx_done();
      repeat (2) @(posedge clk);
      check(exp_tx.size() == 0, "R11 tx bytes complete", exp_tx.size(), 32'h0);
      check(exp_wa.size() == 0, "R11 rx writes complete", exp_wa.size(), 32'h0);
      expect_reg(4'd7, 32'h3, "R11 both done events");
      expect_reg(4'd1, 32'd3, "R11 rx length");

      report();
   end
endmodule